// File: doc/BRIEF.md
# Lane Override and Link Reset Retry Sequencer

This block runs the per-lane PHY override sequence that surrounds a serial ATA link hard reset. It talks to the PHY's control registers through a simple request/acknowledge register port. Each lane's registers sit at a fixed base plus the lane number times 0x100. The block also asks an external reset engine for a link hard reset and reads the link status afterwards.

One pulse on `start` captures the lane and the TX attenuation setting, then runs attempts until one of the exit conditions holds. Each attempt goes through these steps in order:

1. Release the RX override.
2. Hard reset the link.
3. Wait while the lane reports half rate.
4. Re-enable the RX override and reprogram the DPLL mode with a DPLL reset pulse.
5. Wait a settle time.
6. Optionally force the TX attenuation.
7. Read the link status.

When the attempts end, `done` pulses with the final online flag and the number of retries used.

The controller has these states: `S_IDLE`, `S_PRE_RD`, `S_PRE_WR`, `S_HRST`, `S_POLL_RD`, `S_RXM_RD`, `S_RXM_WR`, `S_SETTLE`, `S_TX_RD`, `S_TX_WR`, `S_STAT` and `S_DONE`. Its transitions are:

- `S_IDLE` goes to `S_PRE_RD` on `start`.
- `S_PRE_RD` goes to `S_PRE_WR` on acknowledge.
- `S_PRE_WR` goes to `S_HRST` on acknowledge.
- `S_HRST` goes to `S_POLL_RD` on `hrst_done`.
- `S_POLL_RD` stays in itself while half rate is seen and the poll limit has not been reached. Otherwise it goes to `S_RXM_RD`.
- `S_RXM_RD` goes to `S_RXM_WR` on acknowledge.
- `S_RXM_WR` steps through five writes, then goes to `S_SETTLE`.
- `S_SETTLE` goes to `S_TX_RD` when the timer ends. If attenuation bit 3 is set, it goes to `S_STAT` instead.
- `S_TX_RD` goes to `S_TX_WR` on acknowledge.
- `S_TX_WR` steps through three writes, then goes to `S_STAT`.
- `S_STAT` goes to `S_DONE` or back to `S_PRE_RD`, as R6 describes.
- `S_DONE` goes to `S_IDLE` after one cycle.

Top module: `lane_rst_seq`

## Requirements
- R1: Each attempt begins with a read of RX status at 0x2002 + lane×0x100, followed by a write to RX override at 0x2005 + lane×0x100. The write value is the value just read with bit 14 cleared. `hrst_req` rises only after that write is acknowledged and stays high until `hrst_done`.
- R2: After `hrst_done`, RX status is read again for as long as bit 0 (half rate) of the returned value is 1. At most POLL_MAX+1 such reads are made per attempt.
- R3: Next comes one fresh RX status read (value V), then exactly five writes to RX override, in this order:
  - V with bit 14 cleared.
  - V with bit 14 set.
  - The previous value with bits 10:8 replaced by DPLL_MODE (default 3).
  - That value with bit 11 set.
  - That value with bit 11 clear.
- R4: After the fifth RX override write is acknowledged, at least SETTLE_CYC clock cycles pass before the next request of any kind.
- R5: If `tx_atten[3]` is 1, no TX register access happens. Otherwise the block reads TX status at 0x2001 + lane×0x100 (value U), then writes to TX override at 0x2004 + lane×0x100, in this order:
  - U with bit 15 cleared.
  - U with bit 15 set.
  - U with bit 15 set, OR'd with `tx_atten[2:0]` placed at bits 12:10.
- R6: Each attempt ends with a link status read. The run stops if `stat_fail` is 1, if `stat_det` is 0, or if the last hard reset reported online. It also stops once MAX_RETRY retries (default 100) have been made. Otherwise a new attempt starts at R1.
- R7: At the end, `done` is high for exactly one cycle, and `busy` is low on the next cycle. While `done` is high, `done_online` equals the online flag of the last hard reset, and `done_retries` equals the number of attempts minus one.
- R8: `lane` and `tx_atten` are captured at the `start` that begins a run. A `start` pulse, or a change of `lane`, while `busy` is high has no effect on the run.
- R9: At most one of `reg_req`, `hrst_req` and `stat_req` is high at a time. A request holds its address, direction and data stable until it is acknowledged.
- R10: During and after reset, `busy`, `done`, `reg_req`, `hrst_req` and `stat_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a run when idle |
| lane | input | LANE_W | Lane number, captured at start |
| tx_atten | input | 4 | TX attenuation setting; bit 3 set skips the TX step |
| busy | output | 1 | High while a run is in progress |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 16 | Write data |
| reg_ack | input | 1 | One-cycle acknowledge of the current access |
| reg_rdata | input | 16 | Read data, valid with reg_ack |
| hrst_req | output | 1 | Link hard reset request |
| hrst_done | input | 1 | One-cycle completion of the hard reset |
| hrst_online | input | 1 | Link online flag, valid with hrst_done |
| stat_req | output | 1 | Link status read request |
| stat_ack | input | 1 | One-cycle completion of the status read |
| stat_fail | input | 1 | Status read failed, valid with stat_ack |
| stat_det | input | 2 | Device detect field, valid with stat_ack |
| done | output | 1 | One-cycle end-of-run pulse |
| done_online | output | 1 | Final online flag |
| done_retries | output | RTY_W | Retries used in the run |

## Verification
The hardest cases to reach are those where several attempts run in sequence. These include reaching the full retry limit, and stopping early on a failed status read or a zero detect field in a middle attempt. They also include a half-rate condition that outlasts the poll limit, so the RX mode read returns a value that still has bit 0 set. The bench's stub reset engine reports offline for a chosen number of attempts, and its stub status port injects a failure or a zero detect at a chosen attempt. The stub PHY holds the half-rate bit for a chosen number of reads after each reset, including counts above the poll limit. A model in the bench rebuilds the full expected transaction list for each run and compares it entry by entry.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
    localparam int DW = 16;
    localparam int AW = 16;

    localparam logic [AW-1:0] PHY_BASE = 16'h2000;
    localparam logic [7:0] OFS_TX_STS = 8'h01;
    localparam logic [7:0] OFS_RX_STS = 8'h02;
    localparam logic [7:0] OFS_TX_OVR = 8'h04;
    localparam logic [7:0] OFS_RX_OVR = 8'h05;

    localparam int BIT_HALF     = 0;
    localparam int BIT_DPLL_RST = 11;
    localparam int BIT_RX_EN    = 14;
    localparam int BIT_TX_EN    = 15;
    localparam int DPLL_LSB     = 8;
    localparam int ATT_LSB      = 10;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE_RD,
        S_PRE_WR,
        S_HRST,
        S_POLL_RD,
        S_RXM_RD,
        S_RXM_WR,
        S_SETTLE,
        S_TX_RD,
        S_TX_WR,
        S_STAT,
        S_DONE
    } lrs_state_t;

    typedef enum logic [1:0] {
        SEL_TX_STS,
        SEL_RX_STS,
        SEL_TX_OVR,
        SEL_RX_OVR
    } lrs_sel_t;

    typedef enum logic [1:0] {
        WK_PRE,
        WK_RXM,
        WK_TX
    } lrs_wkind_t;
endpackage

// File: rtl/lrs_addr_gen.sv
module lrs_addr_gen
    import lrs_pkg::*;
#(
    parameter int LANE_W = 2
) (
    input  logic [LANE_W-1:0] lane,
    input  lrs_sel_t          sel,
    output logic [AW-1:0]     addr
);
    localparam int LANE_LSB = 8;

    logic [AW-1:0] lane_off;
    logic [7:0]    ofs;

    always_comb begin
        lane_off = '0;
        lane_off[LANE_LSB+LANE_W-1:LANE_LSB] = lane;
        unique case (sel)
            SEL_TX_STS: ofs = OFS_TX_STS;
            SEL_RX_STS: ofs = OFS_RX_STS;
            SEL_TX_OVR: ofs = OFS_TX_OVR;
            SEL_RX_OVR: ofs = OFS_RX_OVR;
            default:    ofs = OFS_RX_STS;
        endcase
        addr = PHY_BASE + lane_off + {8'h00, ofs};
    end
endmodule

// File: rtl/lrs_wdata.sv
module lrs_wdata
    import lrs_pkg::*;
#(
    parameter int DPLL_MODE = 3
) (
    input  lrs_wkind_t    kind,
    input  logic [2:0]    step,
    input  logic [DW-1:0] cap,
    input  logic [2:0]    atten,
    output logic [DW-1:0] wd
);
    localparam logic [2:0] MODE_BITS = 3'(DPLL_MODE);

    logic [DW-1:0] rx_clr, rx_set, rx_mode, rx_rst, rx_rel;
    logic [DW-1:0] tx_clr, tx_set, tx_att;

    always_comb begin
        rx_clr = cap;
        rx_clr[BIT_RX_EN] = 1'b0;
        rx_set = cap;
        rx_set[BIT_RX_EN] = 1'b1;
        rx_mode = rx_set;
        rx_mode[DPLL_LSB+2:DPLL_LSB] = MODE_BITS;
        rx_rst = rx_mode;
        rx_rst[BIT_DPLL_RST] = 1'b1;
        rx_rel = rx_mode;
        rx_rel[BIT_DPLL_RST] = 1'b0;

        tx_clr = cap;
        tx_clr[BIT_TX_EN] = 1'b0;
        tx_set = cap;
        tx_set[BIT_TX_EN] = 1'b1;
        tx_att = tx_set | ({13'b0, atten} << ATT_LSB);

        unique case (kind)
            WK_PRE: wd = rx_clr;
            WK_RXM: begin
                unique case (step)
                    3'd0:    wd = rx_clr;
                    3'd1:    wd = rx_set;
                    3'd2:    wd = rx_mode;
                    3'd3:    wd = rx_rst;
                    default: wd = rx_rel;
                endcase
            end
            WK_TX: begin
                unique case (step)
                    3'd0:    wd = tx_clr;
                    3'd1:    wd = tx_set;
                    default: wd = tx_att;
                endcase
            end
            default: wd = cap;
        endcase
    end
endmodule

// File: rtl/lrs_counters.sv
module lrs_counters #(
    parameter int POLL_MAX   = 1000,
    parameter int SETTLE_CYC = 3000000,
    parameter int MAX_RETRY  = 100,
    localparam int PW    = $clog2(POLL_MAX + 2),
    localparam int SW    = $clog2(SETTLE_CYC + 2),
    localparam int RTY_W = $clog2(MAX_RETRY + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll_clr,
    input  logic             poll_inc,
    output logic             poll_last,
    input  logic             settle_clr,
    input  logic             settle_run,
    output logic             settle_end,
    input  logic             rty_clr,
    input  logic             rty_inc,
    output logic             rty_last,
    output logic [RTY_W-1:0] rty_cnt
);
    logic [PW-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pcnt <= '0;
        else if (poll_clr) pcnt <= '0;
        else if (poll_inc) pcnt <= pcnt + 1'b1;
    end
    assign poll_last = (pcnt == PW'(POLL_MAX));

    generate
        if (SETTLE_CYC > 1) begin : g_timer
            logic [SW-1:0] scnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          scnt <= '0;
                else if (settle_clr) scnt <= '0;
                else if (settle_run) scnt <= scnt + 1'b1;
            end
            assign settle_end = (scnt == SW'(SETTLE_CYC - 1));
        end else begin : g_no_timer
            assign settle_end = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rty_cnt <= '0;
        else if (rty_clr) rty_cnt <= '0;
        else if (rty_inc) rty_cnt <= rty_cnt + 1'b1;
    end
    assign rty_last = (rty_cnt == RTY_W'(MAX_RETRY));
endmodule

// File: rtl/lane_rst_seq.sv
module lane_rst_seq
    import lrs_pkg::*;
#(
    parameter int LANE_W     = 2,
    parameter int POLL_MAX   = 1000,
    parameter int SETTLE_CYC = 3000000,
    parameter int MAX_RETRY  = 100,
    parameter int DPLL_MODE  = 3,
    localparam int RTY_W     = $clog2(MAX_RETRY + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LANE_W-1:0] lane,
    input  logic [3:0]        tx_atten,
    output logic              busy,
    output logic              reg_req,
    output logic              reg_we,
    output logic [15:0]       reg_addr,
    output logic [15:0]       reg_wdata,
    input  logic              reg_ack,
    input  logic [15:0]       reg_rdata,
    output logic              hrst_req,
    input  logic              hrst_done,
    input  logic              hrst_online,
    output logic              stat_req,
    input  logic              stat_ack,
    input  logic              stat_fail,
    input  logic [1:0]        stat_det,
    output logic              done,
    output logic              done_online,
    output logic [RTY_W-1:0]  done_retries
);
    lrs_state_t        state, nxt;
    logic [2:0]        step, nstep;
    logic [DW-1:0]     cap;
    logic [LANE_W-1:0] lane_q;
    logic [3:0]        atten_q;
    logic              online_q;

    lrs_sel_t   sel;
    lrs_wkind_t wkind;
    logic cap_ld, online_ld;
    logic poll_clr, poll_inc, poll_last;
    logic settle_clr, settle_run, settle_end;
    logic rty_clr, rty_inc, rty_last;
    logic [RTY_W-1:0] rty_cnt;

    lrs_addr_gen #(.LANE_W(LANE_W)) u_addr (
        .lane (lane_q),
        .sel  (sel),
        .addr (reg_addr)
    );

    lrs_wdata #(.DPLL_MODE(DPLL_MODE)) u_wdata (
        .kind  (wkind),
        .step  (step),
        .cap   (cap),
        .atten (atten_q[2:0]),
        .wd    (reg_wdata)
    );

    lrs_counters #(
        .POLL_MAX   (POLL_MAX),
        .SETTLE_CYC (SETTLE_CYC),
        .MAX_RETRY  (MAX_RETRY)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .poll_clr   (poll_clr),
        .poll_inc   (poll_inc),
        .poll_last  (poll_last),
        .settle_clr (settle_clr),
        .settle_run (settle_run),
        .settle_end (settle_end),
        .rty_clr    (rty_clr),
        .rty_inc    (rty_inc),
        .rty_last   (rty_last),
        .rty_cnt    (rty_cnt)
    );

    // State register and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            step     <= '0;
            cap      <= '0;
            lane_q   <= '0;
            atten_q  <= '0;
            online_q <= 1'b0;
        end else begin
            state <= nxt;
            step  <= nstep;
            if (cap_ld)    cap <= reg_rdata;
            if (online_ld) online_q <= hrst_online;
            if (state == S_IDLE && start) begin
                lane_q  <= lane;
                atten_q <= tx_atten;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        nxt        = state;
        nstep      = step;
        reg_req    = 1'b0;
        reg_we     = 1'b0;
        sel        = SEL_RX_STS;
        wkind      = WK_PRE;
        hrst_req   = 1'b0;
        stat_req   = 1'b0;
        cap_ld     = 1'b0;
        online_ld  = 1'b0;
        poll_clr   = 1'b0;
        poll_inc   = 1'b0;
        settle_clr = 1'b0;
        settle_run = 1'b0;
        rty_clr    = 1'b0;
        rty_inc    = 1'b0;

        unique case (state)
            S_IDLE: begin
                if (start) begin
                    rty_clr = 1'b1;
                    nxt     = S_PRE_RD;
                end
            end
            S_PRE_RD: begin
                reg_req = 1'b1;
                sel     = SEL_RX_STS;
                if (reg_ack) begin
                    cap_ld = 1'b1;
                    nxt    = S_PRE_WR;
                end
            end
            S_PRE_WR: begin
                reg_req = 1'b1;
                reg_we  = 1'b1;
                sel     = SEL_RX_OVR;
                wkind   = WK_PRE;
                if (reg_ack) nxt = S_HRST;
            end
            S_HRST: begin
                hrst_req = 1'b1;
                if (hrst_done) begin
                    online_ld = 1'b1;
                    poll_clr  = 1'b1;
                    nxt       = S_POLL_RD;
                end
            end
            S_POLL_RD: begin
                reg_req = 1'b1;
                sel     = SEL_RX_STS;
                if (reg_ack) begin
                    if (reg_rdata[BIT_HALF] && !poll_last) poll_inc = 1'b1;
                    else                                   nxt = S_RXM_RD;
                end
            end
            S_RXM_RD: begin
                reg_req = 1'b1;
                sel     = SEL_RX_STS;
                if (reg_ack) begin
                    cap_ld = 1'b1;
                    nstep  = '0;
                    nxt    = S_RXM_WR;
                end
            end
            S_RXM_WR: begin
                reg_req = 1'b1;
                reg_we  = 1'b1;
                sel     = SEL_RX_OVR;
                wkind   = WK_RXM;
                if (reg_ack) begin
                    if (step == 3'd4) begin
                        settle_clr = 1'b1;
                        nxt        = S_SETTLE;
                    end else begin
                        nstep = step + 3'd1;
                    end
                end
            end
            S_SETTLE: begin
                settle_run = 1'b1;
                if (settle_end) nxt = atten_q[3] ? S_STAT : S_TX_RD;
            end
            S_TX_RD: begin
                reg_req = 1'b1;
                sel     = SEL_TX_STS;
                if (reg_ack) begin
                    cap_ld = 1'b1;
                    nstep  = '0;
                    nxt    = S_TX_WR;
                end
            end
            S_TX_WR: begin
                reg_req = 1'b1;
                reg_we  = 1'b1;
                sel     = SEL_TX_OVR;
                wkind   = WK_TX;
                if (reg_ack) begin
                    if (step == 3'd2) nxt = S_STAT;
                    else              nstep = step + 3'd1;
                end
            end
            S_STAT: begin
                stat_req = 1'b1;
                if (stat_ack) begin
                    if (stat_fail || stat_det == 2'b00 || online_q || rty_last) begin
                        nxt = S_DONE;
                    end else begin
                        rty_inc = 1'b1;
                        nxt     = S_PRE_RD;
                    end
                end
            end
            S_DONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    assign busy         = (state != S_IDLE);
    assign done         = (state == S_DONE);
    assign done_online  = online_q;
    assign done_retries = rty_cnt;
endmodule

// File: rtl/lrs_chk.sv
module lrs_chk #(
    parameter int MAX_RETRY = 100,
    parameter int RTY_W     = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_req,
    input logic             reg_we,
    input logic             reg_ack,
    input logic [15:0]      reg_addr,
    input logic [15:0]      reg_wdata,
    input logic             hrst_req,
    input logic             hrst_done,
    input logic             stat_req,
    input logic             busy,
    input logic             done,
    input logic [RTY_W-1:0] done_retries
);
    // R9
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_req, hrst_req, stat_req}));

    // R9
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));

    // R1
    pre_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hrst_req) |-> $past(reg_ack && reg_we && reg_addr[7:0] == 8'h05));

    // R1
    hrst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hrst_req && !hrst_done |=> hrst_req);

    // R2
    rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_we |-> reg_addr[7:0] == 8'h01 || reg_addr[7:0] == 8'h02);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R6
    rty_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> done_retries <= RTY_W'(MAX_RETRY));
endmodule

bind lane_rst_seq lrs_chk #(.MAX_RETRY(MAX_RETRY), .RTY_W(RTY_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_req      (reg_req),
    .reg_we       (reg_we),
    .reg_ack      (reg_ack),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .hrst_req     (hrst_req),
    .hrst_done    (hrst_done),
    .stat_req     (stat_req),
    .busy         (busy),
    .done         (done),
    .done_retries (done_retries)
);

// File: tb/lane_rst_seq_test.sv
`timescale 1ns/1ps
module lane_rst_seq_test;
    localparam int POLL = 8;
    localparam int SETT = 20;
    localparam int MAXR = 100;
    localparam int LOGN = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] lane = 2'd0;
    logic [3:0] tx_atten = 4'd0;
    logic busy, reg_req, reg_we, hrst_req, stat_req, done, done_online;
    logic [15:0] reg_addr, reg_wdata;
    logic reg_ack = 1'b0;
    logic [15:0] reg_rdata = 16'h0;
    logic hrst_done = 1'b0, hrst_online = 1'b0;
    logic stat_ack = 1'b0, stat_fail = 1'b0;
    logic [1:0] stat_det = 2'd0;
    logic [6:0] done_retries;

    lane_rst_seq #(.LANE_W(2), .POLL_MAX(POLL), .SETTLE_CYC(SETT), .MAX_RETRY(MAXR), .DPLL_MODE(3)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .lane(lane), .tx_atten(tx_atten), .busy(busy),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata), .hrst_req(hrst_req), .hrst_done(hrst_done),
        .hrst_online(hrst_online), .stat_req(stat_req), .stat_ack(stat_ack), .stat_fail(stat_fail),
        .stat_det(stat_det), .done(done), .done_online(done_online), .done_retries(done_retries));

    int tests = 0, fails = 0, cyc = 0;

    // scenario controls
    int sc_rxb, sc_txb, sc_half, sc_nfail, sc_failat, sc_detzat, sc_det;
    int rx_k, att_h, att_s;

    // observed log
    int lk[LOGN], lad[LOGN], ldt[LOGN], lst[LOGN], lac[LOGN];
    int lidx;
    // expected log
    int ek[LOGN], ead[LOGN], edt[LOGN], ereq[LOGN];
    int eidx, exp_ret, exp_onl, set_idx;

    initial forever #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic log_ev(input int k, input int a, input int d, input int st);
        if (lidx < LOGN) begin
            lk[lidx] = k; lad[lidx] = a; ldt[lidx] = d; lst[lidx] = st; lac[lidx] = cyc;
        end
        lidx++;
    endtask

    // register port stub
    initial begin
        int r_in, r_st, r_lat, v;
        r_in = 0; r_st = 0; r_lat = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                reg_ack = 1'b0; r_in = 0;
            end else if (reg_ack) begin
                reg_ack = 1'b0;
                if (reg_req) begin r_in = 1; r_st = cyc; r_lat = $urandom % 3; end
            end else if (reg_req) begin
                if (r_in == 0) begin r_in = 1; r_st = cyc; r_lat = $urandom % 3; end
                if (r_lat == 0) begin
                    if (!reg_we) begin
                        if (reg_addr[7:0] == 8'h02) begin
                            v = sc_rxb | ((rx_k < sc_half) ? 1 : 0);
                            rx_k++;
                        end else v = sc_txb;
                        reg_rdata = 16'(v);
                        log_ev(0, int'(reg_addr), v, r_st);
                    end else log_ev(1, int'(reg_addr), int'(reg_wdata), r_st);
                    reg_ack = 1'b1; r_in = 0;
                end else r_lat--;
            end
        end
    end

    // hard reset stub
    initial begin
        int h_in, h_st, h_lat;
        h_in = 0; h_st = 0; h_lat = 0;
        forever begin
            @(negedge clk);
            if (!rst_n || hrst_done) begin
                hrst_done = 1'b0; h_in = 0;
            end else if (hrst_req) begin
                if (h_in == 0) begin h_in = 1; h_st = cyc; h_lat = $urandom % 4; end
                if (h_lat == 0) begin
                    hrst_online = (att_h >= sc_nfail);
                    att_h++; rx_k = 0;
                    log_ev(2, 0, 0, h_st);
                    hrst_done = 1'b1; h_in = 0;
                end else h_lat--;
            end
        end
    end

    // link status stub
    initial begin
        int s_in, s_st, s_lat;
        s_in = 0; s_st = 0; s_lat = 0;
        forever begin
            @(negedge clk);
            if (!rst_n || stat_ack) begin
                stat_ack = 1'b0; s_in = 0;
            end else if (stat_req) begin
                if (s_in == 0) begin s_in = 1; s_st = cyc; s_lat = $urandom % 3; end
                if (s_lat == 0) begin
                    stat_fail = (att_s == sc_failat);
                    stat_det = (att_s == sc_detzat) ? 2'd0 : 2'(sc_det);
                    att_s++;
                    log_ev(3, 0, 0, s_st);
                    stat_ack = 1'b1; s_in = 0;
                end else s_lat--;
            end
        end
    end

    function automatic int rxv(input int k);
        return sc_rxb | ((k < sc_half) ? 1 : 0);
    endfunction

    task automatic push(input int k, input int a, input int d, input int rq);
        if (eidx < LOGN) begin ek[eidx] = k; ead[eidx] = a; edt[eidx] = d; ereq[eidx] = rq; end
        eidx++;
    endtask

    // expected transaction list from the requirements
    task automatic build_exp(input int ln, input int att);
        int k, c, n, w2, base, a;
        bit onl, stop;
        base = 'h2000 + ln * 'h100;
        eidx = 0; k = 100000; set_idx = -1; a = 0; stop = 0;
        while (!stop) begin
            c = rxv(k); k++;
            push(0, base + 2, c, 1);                       // R1
            push(1, base + 5, c & ~(1 << 14), 1);
            push(2, 0, 0, 1);
            k = 0; onl = (a >= sc_nfail);
            n = 0;
            forever begin                                   // R2
                c = rxv(k); k++;
                push(0, base + 2, c, 2);
                if ((c & 1) && n < POLL) n++;
                else break;
            end
            c = rxv(k); k++;                                // R3
            push(0, base + 2, c, 3);
            push(1, base + 5, c & ~(1 << 14), 3);
            push(1, base + 5, c | (1 << 14), 3);
            w2 = ((c | (1 << 14)) & ~'h700) | (3 << 8);
            push(1, base + 5, w2, 3);
            push(1, base + 5, w2 | (1 << 11), 3);
            push(1, base + 5, w2 & ~(1 << 11), 3);
            if (a == 0) set_idx = eidx - 1;
            if ((att & 8) == 0) begin                       // R5
                push(0, base + 1, sc_txb, 5);
                push(1, base + 4, sc_txb & ~(1 << 15), 5);
                push(1, base + 4, sc_txb | (1 << 15), 5);
                push(1, base + 4, sc_txb | (1 << 15) | ((att & 7) << 10), 5);
            end
            push(3, 0, 0, 6);                               // R6
            if (a == sc_failat || a == sc_detzat || onl || a == MAXR) begin
                stop = 1; exp_ret = a; exp_onl = onl;
            end else a++;
        end
    endtask

    task automatic run(input int ln, input int att, input int rxb, input int txb, input int half,
                       input int nfail, input int failat, input int detzat, input bit mid_start);
        bit bad[1:6];
        int bact[1:6], bexp[1:6];
        int to, r;
        bit got;
        sc_rxb = rxb & 'hfffe; sc_txb = txb & 'hffff; sc_half = half; sc_nfail = nfail;
        sc_failat = failat; sc_detzat = detzat; sc_det = 1 + ($urandom % 3);
        rx_k = 100000; att_h = 0; att_s = 0; lidx = 0;
        for (int i = 1; i <= 6; i++) begin bad[i] = 0; bact[i] = 0; bexp[i] = 0; end
        @(negedge clk);
        lane = 2'(ln); tx_atten = 4'(att); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mid_start) begin
            repeat (6) @(negedge clk);
            lane = ~lane; tx_atten = ~tx_atten; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        got = 0;
        for (to = 0; to < 30000; to++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        build_exp(ln, att);
        check(got, "R7 done pulse seen", int'(got), 1);
        if (!got) return;
        check(done_online == exp_onl, "R7 done_online", int'(done_online), exp_onl);
        check(int'(done_retries) == exp_ret, "R6 retries used", int'(done_retries), exp_ret);
        for (int i = 0; i < LOGN; i++) begin
            if (i >= lidx && i >= eidx) break;
            r = (i < eidx) ? ereq[i] : 6;
            if (i >= lidx || i >= eidx || lk[i] != ek[i] || lad[i] != ead[i] || ldt[i] != edt[i]) begin
                if (!bad[r]) begin
                    bad[r] = 1;
                    bact[r] = (i < lidx) ? ldt[i] : -1;
                    bexp[r] = (i < eidx) ? edt[i] : -1;
                end
            end
        end
        check(!bad[1], "R1 pre-reset release", bact[1], bexp[1]);
        check(!bad[2], "R2 half-rate polling", bact[2], bexp[2]);
        check(!bad[3], "R3 RX override writes", bact[3], bexp[3]);
        check(!bad[5], "R5 TX attenuation writes", bact[5], bexp[5]);
        check(!bad[6], "R6 status and retry sequence", bact[6], bexp[6]);
        if (set_idx >= 0 && set_idx + 1 < lidx) begin
            int gap;
            gap = lst[set_idx + 1] - lac[set_idx];
            check(gap >= SETT && gap <= SETT + 3, "R4 settle gap", gap, SETT + 1);
        end
        if (mid_start)
            check(!bad[1] && !bad[3] && !bad[5], "R8 start while busy ignored", lidx, eidx);
        @(negedge clk);
        check(!done && !busy, "R7 done single cycle", {30'd0, done, busy}, 0);
        if (mid_start) begin
            repeat (3) @(negedge clk);
            check(!busy && !reg_req, "R8 no second run", {30'd0, busy, reg_req}, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2468));
        sc_rxb = 0; sc_txb = 0; sc_half = 0; sc_nfail = 0; sc_failat = -1; sc_detzat = -1; sc_det = 1;
        rx_k = 0; att_h = 0; att_s = 0; lidx = 0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !reg_req && !hrst_req && !stat_req, "R10 in reset",
              {27'd0, busy, done, reg_req, hrst_req, stat_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !done && !reg_req && !hrst_req && !stat_req, "R10 after reset",
              {27'd0, busy, done, reg_req, hrst_req, stat_req}, 0);

        // directed corners
        run(0, 'h5, 'h4a5c, 'h1234, 0, 0, -1, -1, 0);        // first try online
        run(3, 'hb, 'hcf10, 'h8888, 3, 0, -1, -1, 0);        // TX skipped, 3 half-rate reads
        run(1, 'h7, 'h0b00, 'h7fff, 1, 2, -1, -1, 0);        // two retries
        run(2, 'h2, 'h4800, 'hffff, 0, 5, 1, -1, 0);         // status read fails at attempt 1
        run(1, 'h0, 'h0002, 'h0000, 0, 3, -1, 0, 0);         // detect zero at attempt 0
        run(0, 'h3, 'h1236, 'h0400, 20, 0, -1, -1, 0);       // half-rate outlasts poll limit
        run(2, 'h1, 'h5a5a, 'ha5a5, 2, 1, -1, -1, 1);        // start pulse while busy
        run(3, 'h6, 'hffff, 'h0001, 0, 1000, -1, -1, 0);     // retry limit reached
        // random mix
        for (int n = 0; n < 10; n++) begin
            int fa, dz;
            fa = (($urandom % 4) == 0) ? int'($urandom % 3) : -1;
            dz = (($urandom % 4) == 0) ? int'($urandom % 3) : -1;
            run(int'($urandom % 4), int'($urandom % 16), int'($urandom % 65536),
                int'($urandom % 65536), int'($urandom % 11), int'($urandom % 4), fa, dz,
                bit'($urandom % 2));
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule